// File: doc/BRIEF.md
# Register-Mapped 32x32 Multiplier

This block is a multiplier attached to a narrow synchronous register bus. Software builds two 32-bit operands from 16-bit halves. The product is 64 bits wide and is read back as four 16-bit words.

The address of the write to the low half of the first operand sets the mode. One address selects unsigned multiplication and the other selects signed multiplication. A write to the low half also clears the upper half of the first operand, so a 16-bit operand needs only one write. A write to the upper half of the second operand starts the multiply. The product register is loaded on that same clock edge. The product then stays unchanged until the next such write.

Read data is registered. The word for the address presented in one cycle appears on the read port after the next clock edge. Offsets that are not listed below read as zero, and writes to them have no effect. The product words cannot be written.

Top module: `mmul32_regs`

## Requirements
- R1: After reset, both operands and the product are zero and the mode is unsigned. Every product word reads 0x0000. A multiply started with no write to the operand-1 low half is unsigned.
- R2: A write to offset 0x140 loads the data into bits 15:0 of operand 1 and clears bits 31:16. It also selects unsigned mode.
- R3: A write to offset 0x144 loads the data into bits 15:0 of operand 1 and clears bits 31:16. It also selects signed mode.
- R4: A write to offset 0x142 or to offset 0x146 replaces bits 31:16 of operand 1. Bits 15:0 of operand 1 and the current mode are kept.
- R5: A write to offset 0x150 loads bits 15:0 of operand 2 and leaves the product unchanged.
- R6: A write to offset 0x152 replaces bits 31:16 of operand 2. On the same clock edge, the product register is loaded with the 64-bit product of operand 1 and the updated operand 2.
- R7: In signed mode, both operands are treated as two's-complement 32-bit values. The product is their full 64-bit two's-complement product.
- R8: Reads at offsets 0x154, 0x156, 0x158 and 0x15A return product bits 15:0, 31:16, 47:32 and 63:48 in that order. The data appears one clock after the address is presented.
- R9: Any other offset, including the product offsets when written, reads as zero and ignores writes. Operands, mode and product are left unchanged.
- R10: The product holds its value across every cycle that has no write to offset 0x152.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_addr | input | ADDR_W (12) | Byte offset of the 16-bit register |
| bus_wdata | input | DATA_W (16) | Write data |
| bus_rdata | output | DATA_W (16) | Registered read data for the address of the previous cycle |

## Verification
The properties assume that `bus_we` and `bus_addr` carry known values in every cycle after reset. A property that looks at a multiply-start write also assumes that write is seen at a single edge. The bench therefore drives every input from time zero and changes inputs only on the falling edge. It releases `bus_we` after exactly one rising edge. Random traffic is limited to even offsets in and around the register window. This mixes mapped and unmapped writes with product reads, including a read of a product word in the same cycle as a new multiply.

// File: rtl/mmul_pkg.sv
package mmul_pkg;
  // Register offsets (byte addresses of 16-bit words)
  localparam int unsigned OFS_A_LO_UNS = 'h140;
  localparam int unsigned OFS_A_HI_UNS = 'h142;
  localparam int unsigned OFS_A_LO_SGN = 'h144;
  localparam int unsigned OFS_A_HI_SGN = 'h146;
  localparam int unsigned OFS_B_LO     = 'h150;
  localparam int unsigned OFS_B_HI     = 'h152;
  localparam int unsigned OFS_P_BASE   = 'h154;
  localparam int unsigned WORD_STRIDE  = 2;

  typedef enum logic {MODE_UNS = 1'b0, MODE_SGN = 1'b1} mul_mode_e;
endpackage

// File: rtl/mmul_opregs.sv
module mmul_opregs
  import mmul_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12,
  localparam int OP_W  = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [OP_W-1:0]   op_a,
  output logic [OP_W-1:0]   op_b_next,
  output mul_mode_e         mode,
  output logic              fire
);
  logic [OP_W-1:0] op_b;

  logic hit_a_lo_u, hit_a_lo_s, hit_a_hi, hit_b_lo;

  assign hit_a_lo_u = we && (addr == ADDR_W'(OFS_A_LO_UNS));
  assign hit_a_lo_s = we && (addr == ADDR_W'(OFS_A_LO_SGN));
  assign hit_a_hi   = we && ((addr == ADDR_W'(OFS_A_HI_UNS)) ||
                             (addr == ADDR_W'(OFS_A_HI_SGN)));
  assign hit_b_lo   = we && (addr == ADDR_W'(OFS_B_LO));
  assign fire       = we && (addr == ADDR_W'(OFS_B_HI));

  // Operand 2 as it will be after this cycle's trigger write
  assign op_b_next  = fire ? {wdata, op_b[DATA_W-1:0]} : op_b;

  always_ff @(posedge clk) begin
    if (rst) begin
      op_a <= '0;
      op_b <= '0;
      mode <= MODE_UNS;
    end else begin
      if (hit_a_lo_u || hit_a_lo_s) begin
        op_a <= {{DATA_W{1'b0}}, wdata};
        mode <= hit_a_lo_s ? MODE_SGN : MODE_UNS;
      end else if (hit_a_hi) begin
        op_a <= {wdata, op_a[DATA_W-1:0]};
      end
      if (hit_b_lo) begin
        op_b <= {op_b[OP_W-1:DATA_W], wdata};
      end else if (fire) begin
        op_b <= op_b_next;
      end
    end
  end
endmodule

// File: rtl/mmul_core.sv
module mmul_core
  import mmul_pkg::*;
#(
  parameter int DATA_W  = 16,
  localparam int OP_W   = 2 * DATA_W,
  localparam int PROD_W = 2 * OP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  mul_mode_e         mode,
  input  logic [OP_W-1:0]   op_a,
  input  logic [OP_W-1:0]   op_b,
  output logic [PROD_W-1:0] prod
);
  logic              ext_a, ext_b;
  logic [PROD_W-1:0] wide_a, wide_b, prod_next;

  // Extend to product width; the truncated product is exact either way
  assign ext_a     = (mode == MODE_SGN) && op_a[OP_W-1];
  assign ext_b     = (mode == MODE_SGN) && op_b[OP_W-1];
  assign wide_a    = {{OP_W{ext_a}}, op_a};
  assign wide_b    = {{OP_W{ext_b}}, op_b};
  assign prod_next = wide_a * wide_b;

  always_ff @(posedge clk) begin
    if (rst) begin
      prod <= '0;
    end else if (fire) begin
      prod <= prod_next;
    end
  end
endmodule

// File: rtl/mmul_rdmux.sv
module mmul_rdmux
  import mmul_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 12,
  localparam int PROD_W = 4 * DATA_W,
  localparam int LANES  = PROD_W / DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [PROD_W-1:0] prod,
  output logic [DATA_W-1:0] rdata
);
  logic [LANES-1:0]  lane_hit;
  logic [DATA_W-1:0] word;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_hit[g] = (addr == ADDR_W'(OFS_P_BASE + g * WORD_STRIDE));
  end

  always_comb begin
    word = '0;
    for (int i = 0; i < LANES; i++) begin
      if (lane_hit[i]) word = word | prod[i*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= word;
  end
endmodule

// File: rtl/mmul32_regs.sv
module mmul32_regs
  import mmul_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);
  localparam int OP_W   = 2 * DATA_W;
  localparam int PROD_W = 2 * OP_W;

  logic [OP_W-1:0]   op1_q;
  logic [OP_W-1:0]   op2_nxt;
  logic [PROD_W-1:0] prod_q;
  mul_mode_e         mode_q;
  logic              sgn_q;
  logic              trig;

  assign sgn_q = (mode_q == MODE_SGN);

  mmul_opregs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ops (
    .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .op_a(op1_q), .op_b_next(op2_nxt), .mode(mode_q), .fire(trig)
  );

  mmul_core #(.DATA_W(DATA_W)) u_core (
    .clk(clk), .rst(rst), .fire(trig), .mode(mode_q),
    .op_a(op1_q), .op_b(op2_nxt), .prod(prod_q)
  );

  mmul_rdmux #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
    .clk(clk), .rst(rst), .addr(bus_addr), .prod(prod_q), .rdata(bus_rdata)
  );
endmodule

// File: rtl/mmul32_regs_chk.sv
module mmul32_regs_chk
  import mmul_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 12,
  localparam int OP_W   = 2 * DATA_W,
  localparam int PROD_W = 2 * OP_W
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [OP_W-1:0]   op1_q,
  input logic              sgn_q,
  input logic [PROD_W-1:0] prod_q
);
  logic readable;
  assign readable = (bus_addr >= ADDR_W'(OFS_P_BASE)) &&
                    (bus_addr <= ADDR_W'(OFS_P_BASE + 3 * WORD_STRIDE)) &&
                    !bus_addr[0];

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (bus_rdata == '0 && prod_q == '0 && !sgn_q && op1_q == '0)); // R1

  AST_UNS_LOAD: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == ADDR_W'(OFS_A_LO_UNS)) |=>
      (!sgn_q && op1_q[OP_W-1:DATA_W] == '0)); // R2

  AST_SGN_LOAD: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == ADDR_W'(OFS_A_LO_SGN)) |=>
      (sgn_q && op1_q[OP_W-1:DATA_W] == '0)); // R3

  AST_HI_KEEPS_LO: assert property (@(posedge clk) disable iff (rst)
    (bus_we && (bus_addr == ADDR_W'(OFS_A_HI_UNS) || bus_addr == ADDR_W'(OFS_A_HI_SGN))) |=>
      (op1_q[DATA_W-1:0] == $past(op1_q[DATA_W-1:0]) && sgn_q == $past(sgn_q))); // R4

  AST_LANE0_READ: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == ADDR_W'(OFS_P_BASE)) |=> (bus_rdata == $past(prod_q[DATA_W-1:0]))); // R8

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    !readable |=> (bus_rdata == '0)); // R9

  AST_PROD_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !(bus_we && bus_addr == ADDR_W'(OFS_B_HI)) |=> $stable(prod_q)); // R10
endmodule

bind mmul32_regs mmul32_regs_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .op1_q(op1_q), .sgn_q(sgn_q), .prod_q(prod_q)
);

// File: tb/mmul32_regs_test.sv
module mmul32_regs_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  mmul32_regs uut (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  // Behavioural reference model
  bit [31:0] m_a, m_b;
  bit        m_sgn;
  bit [63:0] m_p;
  bit [15:0] m_rd;

  function automatic bit [15:0] model_read(bit [11:0] a, bit [63:0] p);
    case (a)
      12'h154: return p[15:0];
      12'h156: return p[31:16];
      12'h158: return p[47:32];
      12'h15A: return p[63:48];
      default: return 16'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_a = 0; m_b = 0; m_sgn = 0; m_p = 0; m_rd = 0;
    end else begin
      m_rd = model_read(bus_addr, m_p);
      if (bus_we) begin
        case (bus_addr)
          12'h140: begin m_a = {16'h0, bus_wdata}; m_sgn = 0; end
          12'h144: begin m_a = {16'h0, bus_wdata}; m_sgn = 1; end
          12'h142, 12'h146: m_a[31:16] = bus_wdata;
          12'h150: m_b[15:0] = bus_wdata;
          12'h152: begin
            m_b[31:16] = bus_wdata;
            if (m_sgn) m_p = 64'(longint'(int'(m_a)) * longint'(int'(m_b)));
            else       m_p = 64'(longint'(m_a) * longint'(m_b));
          end
          default: ;
        endcase
      end
    end
  end

  // Compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (bus_rdata !== m_rd) begin
        errors++;
        $display("FAIL %s model compare: actual %h expected %h",
                 rst ? "R1" : "R8/R9", bus_rdata, m_rd);
      end
    end
  end

  task automatic wr(input bit [11:0] a, input bit [15:0] d);
    bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd(input bit [11:0] a, input bit [15:0] exp, input string tag);
    bus_we = 0; bus_addr = a;
    @(negedge clk);
    checks++;
    if (bus_rdata !== exp) begin
      errors++;
      $display("FAIL %s read %h: actual %h expected %h", tag, a, bus_rdata, exp);
    end
  endtask

  task automatic rd4(input bit [63:0] exp, input string tag);
    rd(12'h154, exp[15:0], tag);
    rd(12'h156, exp[31:16], tag);
    rd(12'h158, exp[47:32], tag);
    rd(12'h15A, exp[63:48], tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: cleared product, unsigned by default
    rd4(64'h0, "R1");
    wr(12'h142, 16'hFFFF);
    wr(12'h150, 16'h0002);
    wr(12'h152, 16'hFFFF);
    rd4(64'hFFFE_0002_FFFE_0000, "R1 unsigned default R6");
    // R2: low write clears upper half
    wr(12'h142, 16'h1234);
    wr(12'h140, 16'h0003);
    wr(12'h150, 16'h0005);
    wr(12'h152, 16'h0000);
    rd4(64'd15, "R2");
    // R4, R7: signed -2 * 3
    wr(12'h144, 16'hFFFE);
    wr(12'h146, 16'hFFFF);
    wr(12'h150, 16'h0003);
    wr(12'h152, 16'h0000);
    rd4(64'hFFFF_FFFF_FFFF_FFFA, "R4 R7");
    // R3: signed low write clears upper half -> +32768 * -1
    wr(12'h144, 16'h8000);
    wr(12'h150, 16'hFFFF);
    wr(12'h152, 16'hFFFF);
    rd4(64'hFFFF_FFFF_FFFF_8000, "R3");
    // R5, R10: operand writes leave product alone
    wr(12'h150, 16'h0007);
    rd(12'h154, 16'h8000, "R5");
    wr(12'h146, 16'h0000);
    rd(12'h15A, 16'hFFFF, "R10");
    // R9: unmapped and read-only offsets
    wr(12'h148, 16'hAAAA);
    wr(12'h154, 16'h1111);
    wr(12'h13A, 16'h5555);
    rd(12'h148, 16'h0, "R9");
    rd(12'h154, 16'h8000, "R9");
    wr(12'h152, 16'h0000);
    rd4(64'h0000_0000_0003_8000, "R9 R6");
    // R6 unsigned extremes, then R7 signed with same operand 2
    wr(12'h140, 16'hFFFF);
    wr(12'h142, 16'hFFFF);
    wr(12'h150, 16'hFFFF);
    wr(12'h152, 16'hFFFF);
    rd4(64'hFFFF_FFFE_0000_0001, "R6");
    wr(12'h144, 16'hFFFF);
    wr(12'h146, 16'hFFFF);
    wr(12'h152, 16'hFFFF);
    rd4(64'h1, "R7");
    // Mixed traffic, checked by the model (R8 R9)
    for (int i = 0; i < 400; i++) begin
      bus_addr  = 12'h13C + 12'(2 * ($urandom % 18));
      bus_wdata = 16'($urandom);
      bus_we    = ($urandom % 3) != 0;
      @(negedge clk);
    end
    bus_we = 0;
    @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule